// File: doc/BRIEF.md
# Serial Seconds-Counter Register Slave

This block is the clock-domain end of a three-wire serial register port. It keeps a 32-bit seconds counter that counts up once for every cycle in which the one-second enable is high. It also keeps a 32-bit seconds-adjust register. A host reaches either register through a select line, a serial clock and a data-in line, and reads results back on a data-out line.

The host frames an access in three parts. First it raises the select line and clocks in a short register address. Then it lowers the select line and clocks in a single direction bit. Last, it either shifts in 32 data bits or shifts out 32 data bits. The three serial inputs may change at any time relative to the system clock. They are brought into the clock domain through synchronizers, and every bit is taken on a rising edge of the serial clock once that edge has been synchronized.

A ready output tells the host when a new access may start. Before each access the host drives all three inputs low and waits for ready to be high.

Top module: `srtc_serial_slave`

## Requirements
- R1: An access starts on a rising edge of the select line. While select is high, 3 address bits are taken MSB first, one on each serial-clock rising edge. After that, one direction bit is taken on a serial-clock rising edge with select low. A direction value of 1 means the host writes; 0 means the host reads.
- R2: In a write, the 32 data bits arrive on the data-in line MSB first, one on each serial-clock rising edge, and the addressed register takes the complete word.
- R3: In a read, after the k-th serial-clock rising edge of the data phase (k = 1..32), data-out shows bit 32-k of the word being read. Data-out does not change at any other time.
- R4: Address 0 selects the seconds counter and address 2 selects the adjust register. Both can be written and read back.
- R5: In each cycle that the tick enable is high, the counter goes up by one. After 0xFFFFFFFF it wraps to 0.
- R6: A write to the counter loads it after the 32nd data bit. If a tick arrives in the same cycle as the load, the load wins.
- R7: A read returns the register value as it was when the direction bit was taken. Ticks that arrive later in the same read do not change the result.
- R8: Addresses 1 and 3 to 7 read as zero. Writes to them change neither register.
- R9: Ready is high after reset and whenever no access is in progress. It is low from the start of an access until the access has finished, including the register update at the end of a write.
- R10: A rising edge on select during any phase drops the partial access and restarts the address phase. A write that is cut off this way changes no register.
- R11: Reset clears the counter, the adjust register and data-out to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-second count enable, synchronous to clk |
| ser_en_i | input | 1 | Serial select; frames the address phase |
| ser_clk_i | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_din_i | input | 1 | Serial data from the host |
| ser_dout_o | output | 1 | Serial read data to the host |
| ready_o | output | 1 | High when a new access may start |

## Verification
A walking one is written to the adjust register and read back across all 32 positions. A single swapped or lost bit in either shift direction therefore shows up at one particular position. An address sweep writes a distinct word to each of the eight addresses and then reads them all back. This tells decoded addresses from unimplemented ones, and shows whether a write to an unimplemented address reaches a real register.

Tick pulses go in at three points: between accesses, across the counter's wrap point, and during the data phase of a read. These separate plain counting, wrap-around, and the read snapshot. A tick held high through the end of a counter write checks the load priority. Two frames that are cut off, one in the address phase and one in the data phase, check that a restart leaves no trace.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DIR  = 3'd2,
    ST_DATA = 3'd3,
    ST_UPD  = 3'd4
  } srtc_state_e;

endpackage

// File: rtl/srtc_sync.sv
module srtc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/srtc_frame.sv
module srtc_frame
  import srtc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_i,
  input  logic              sdi_i,
  input  logic              sclk_rise_i,
  input  logic              sen_rise_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              ready_o
);

  localparam int MAX_BITS = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W    = $clog2(MAX_BITS);

  srtc_state_e       state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              dir_q, dir_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              sdo_q, sdo_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    addr_n  = addr_q;
    dir_n   = dir_q;
    sh_n    = sh_q;
    sdo_n   = sdo_q;
    if (sen_rise_i) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      addr_n  = '0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (sclk_rise_i && sen_i) begin
            addr_n = {addr_q[ADDR_W-2:0], sdi_i};
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              cnt_n   = '0;
              state_n = ST_DIR;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_DIR: begin
          if (sclk_rise_i && !sen_i) begin
            dir_n   = sdi_i;
            cnt_n   = '0;
            state_n = ST_DATA;
            if (!sdi_i) sh_n = rd_data_i;
          end
        end
        ST_DATA: begin
          if (sclk_rise_i) begin
            if (dir_q) begin
              sh_n = {sh_q[DATA_W-2:0], sdi_i};
            end else begin
              sdo_n = sh_q[DATA_W-1];
              sh_n  = {sh_q[DATA_W-2:0], 1'b0};
            end
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              cnt_n   = '0;
              state_n = dir_q ? ST_UPD : ST_IDLE;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_UPD:  state_n = ST_IDLE;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      dir_q   <= 1'b0;
      sh_q    <= '0;
      sdo_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      addr_q  <= addr_n;
      dir_q   <= dir_n;
      sh_q    <= sh_n;
      sdo_q   <= sdo_n;
    end
  end

  assign addr_o    = addr_q;
  assign wr_en_o   = (state_q == ST_UPD);
  assign wr_data_o = sh_q;
  assign sdo_o     = sdo_q;
  assign ready_o   = (state_q == ST_IDLE);

  // R10: a select rising edge always restarts the address phase
  assert_sen_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sen_rise_i |=> (state_q == ST_ADDR && cnt_q == '0));

  // R9: the block reports busy right after an access begins
  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sen_rise_i |=> !ready_o);

  // R3: data-out moves only on data-phase serial-clock edges of a read
  assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_q == ST_DATA && sclk_rise_i && !dir_q && !sen_rise_i) |=> $stable(sdo_q));

endmodule

// File: rtl/srtc_regs.sv
module srtc_regs #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32,
  parameter int CNT_ADDR = 0,
  parameter int ADJ_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam logic [ADDR_W-1:0] CNT_SEL = ADDR_W'(CNT_ADDR);
  localparam logic [ADDR_W-1:0] ADJ_SEL = ADDR_W'(ADJ_ADDR);

  logic [DATA_W-1:0] cnt_q, cnt_n;
  logic [DATA_W-1:0] adj_q;
  logic              cnt_load, cnt_en, adj_en;

  assign cnt_load = wr_en_i && (addr_i == CNT_SEL);
  assign cnt_en   = cnt_load || tick_i;
  assign cnt_n    = cnt_load ? wr_data_i : (cnt_q + 1'b1);
  assign adj_en   = wr_en_i && (addr_i == ADJ_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      adj_q <= '0;
    else if (adj_en) adj_q <= wr_data_i;
  end

  always_comb begin
    if (addr_i == CNT_SEL)      rd_data_o = cnt_q;
    else if (addr_i == ADJ_SEL) rd_data_o = adj_q;
    else                        rd_data_o = '0;
  end

  // R6: a counter write wins over a coincident tick
  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == CNT_SEL) |=> (cnt_q == $past(wr_data_i)));

  // R5: a lone tick advances the counter by one
  assert_tick_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !(wr_en_i && addr_i == CNT_SEL)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4: the adjust register takes the written word
  assert_adj_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADJ_SEL) |=> (adj_q == $past(wr_data_i)));

  // R8: writes elsewhere leave the adjust register alone
  assert_adj_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADJ_SEL) |=> $stable(adj_q));

endmodule

// File: rtl/srtc_serial_slave.sv
module srtc_serial_slave #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_ADDR    = 0,
  parameter int ADJ_ADDR    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ser_en_i,
  input  logic ser_clk_i,
  input  logic ser_din_i,
  output logic ser_dout_o,
  output logic ready_o
);

  logic              rst_meta_q, rst_sync_n;
  logic [2:0]        line_s;
  logic              sen_s, sclk_s, sdi_s;
  logic              sen_d_q, sclk_d_q;
  logic              sen_rise, sclk_rise;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  srtc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({ser_en_i, ser_clk_i, ser_din_i}),
    .q_o   (line_s)
  );

  assign sen_s  = line_s[2];
  assign sclk_s = line_s[1];
  assign sdi_s  = line_s[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sen_d_q  <= 1'b0;
      sclk_d_q <= 1'b0;
    end else begin
      sen_d_q  <= sen_s;
      sclk_d_q <= sclk_s;
    end
  end

  assign sen_rise  = sen_s  & ~sen_d_q;
  assign sclk_rise = sclk_s & ~sclk_d_q;

  srtc_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sen_i       (sen_s),
    .sdi_i       (sdi_s),
    .sclk_rise_i (sclk_rise),
    .sen_rise_i  (sen_rise),
    .rd_data_i   (rd_data),
    .addr_o      (addr),
    .wr_en_o     (wr_en),
    .wr_data_o   (wr_data),
    .sdo_o       (ser_dout_o),
    .ready_o     (ready_o)
  );

  srtc_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_ADDR (CNT_ADDR),
    .ADJ_ADDR (ADJ_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data)
  );

endmodule

// File: tb/srtc_serial_slave_tb_top.sv
`timescale 1ns/1ps
module srtc_serial_slave_tb_top;

  localparam int GAP = 6;

  logic clk, rst_n, tick, sen, sclk, sdi;
  logic sdo, ready;
  int   n_checks, n_fails;
  bit   done;

  srtc_serial_slave dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .ser_en_i   (sen),
    .ser_clk_i  (sclk),
    .ser_din_i  (sdi),
    .ser_dout_o (sdo),
    .ready_o    (ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit trail);
    sdi = b;
    idle(GAP);
    sclk = 1'b0;
    idle(GAP);
    sclk = 1'b1;
    if (trail) idle(GAP);
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wait_ready();
    int guard;
    guard = 0;
    while (!ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // tmode: 0 none, 1 tick after every read bit, 2 tick held through the end of a write
  task automatic frame_body(input bit wr, input logic [2:0] a, input logic [31:0] d,
                            input int tmode, output logic [31:0] rd);
    rd = '0;
    sen = 1'b1;
    idle(GAP);
    for (int i = 2; i >= 0; i--) send_bit(a[i], 1'b1);
    sen = 1'b0;
    sdi = 1'b0;
    idle(GAP);
    send_bit(wr, 1'b1);
    sdi = 1'b0;
    if (wr) begin
      for (int i = 31; i >= 0; i--) begin
        if (i == 0 && tmode == 2) tick = 1'b1;
        send_bit(d[i], i != 0);
      end
      wait_ready();
      tick = 1'b0;
    end else begin
      for (int i = 31; i >= 0; i--) begin
        send_bit(1'b0, 1'b1);
        rd = {rd[30:0], sdo};
        if (tmode == 1) pulse_tick(1);
      end
    end
  endtask

  task automatic access(input bit wr, input logic [2:0] a, input logic [31:0] d,
                        input int tmode, output logic [31:0] rd);
    sdi = 1'b0; sen = 1'b0; sclk = 1'b0;
    idle(GAP);
    wait_ready();
    frame_body(wr, a, d, tmode, rd);
  endtask

  initial begin
    int guard;
    guard = 0;
    while (!done && guard < 190000) begin
      @(posedge clk);
      guard++;
    end
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, tmp;
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b0; sen = 1'b0; sclk = 1'b0; sdi = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R11 / R9: reset state
    check("R9 ready after reset", {31'd0, ready}, 32'd1);
    check("R11 sdo after reset", {31'd0, sdo}, 32'd0);
    access(1'b0, 3'd0, '0, 0, rd); check("R11 counter reset", rd, 32'd0);
    access(1'b0, 3'd2, '0, 0, rd); check("R11 adjust reset", rd, 32'd0);

    // R1 R2 R4: basic write and read-back
    access(1'b1, 3'd0, 32'h1234_5678, 0, rd);
    access(1'b0, 3'd0, '0, 0, rd); check("R4 counter readback", rd, 32'h1234_5678);
    access(1'b1, 3'd2, 32'hA5C3_0F96, 0, rd);
    access(1'b0, 3'd2, '0, 0, rd); check("R1 adjust readback", rd, 32'hA5C3_0F96);

    // R2 R3: walking one through every bit position
    for (int b = 0; b < 32; b++) begin
      access(1'b1, 3'd2, 32'd1 << b, 0, rd);
      access(1'b0, 3'd2, '0, 0, rd);
      check("R3 walking one", rd, 32'd1 << b);
    end

    // R8: address sweep
    for (int a = 0; a < 8; a++) access(1'b1, 3'(a), 32'h1000_0000 + a * 32'h0111_1111, 0, rd);
    for (int a = 0; a < 8; a++) begin
      access(1'b0, 3'(a), '0, 0, rd);
      if (a == 0 || a == 2) check("R8 implemented address", rd, 32'h1000_0000 + a * 32'h0111_1111);
      else                  check("R8 unimplemented reads zero", rd, 32'd0);
    end

    // R5: counting and wrap
    access(1'b1, 3'd0, 32'd100, 0, rd);
    pulse_tick(5);
    access(1'b0, 3'd0, '0, 0, rd); check("R5 tick count", rd, 32'd105);
    access(1'b1, 3'd0, 32'hFFFF_FFFE, 0, rd);
    pulse_tick(2);
    access(1'b0, 3'd0, '0, 0, rd); check("R5 wrap", rd, 32'd0);

    // R6: tick held through the load cycle
    access(1'b1, 3'd0, 32'hCAFE_0001, 2, rd);
    access(1'b0, 3'd0, '0, 0, rd); check("R6 load wins", rd, 32'hCAFE_0001);

    // R7: ticks during a read do not disturb it
    access(1'b1, 3'd0, 32'd500, 0, rd);
    access(1'b0, 3'd0, '0, 1, rd); check("R7 snapshot", rd, 32'd500);
    access(1'b0, 3'd0, '0, 0, rd); check("R7 ticks still counted", rd, 32'd532);

    // R9: busy during an access
    sdi = 1'b0; sclk = 1'b0; idle(GAP);
    sen = 1'b1; idle(GAP);
    check("R9 busy in frame", {31'd0, ready}, 32'd0);
    sen = 1'b0; idle(GAP);
    sen = 1'b1; idle(GAP);
    sen = 1'b0; idle(GAP);
    // finish this stuck frame by restarting it (R10)
    frame_body(1'b0, 3'd2, '0, 0, rd);
    idle(GAP);
    check("R9 ready after read", {31'd0, ready}, 32'd1);

    // R10: abort in the address phase
    sdi = 1'b0; sclk = 1'b0; idle(GAP);
    sen = 1'b1; idle(GAP);
    send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b1);
    sen = 1'b0; sclk = 1'b0; idle(GAP);
    frame_body(1'b1, 3'd2, 32'h1357_9BDF, 0, rd);
    access(1'b0, 3'd2, '0, 0, rd); check("R10 address abort", rd, 32'h1357_9BDF);

    // R10: abort in the data phase of a counter write
    access(1'b1, 3'd0, 32'd77, 0, rd);
    sdi = 1'b0; sen = 1'b0; sclk = 1'b0; idle(GAP);
    wait_ready();
    sen = 1'b1; idle(GAP);
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b1);
    sen = 1'b0; idle(GAP);
    send_bit(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b1);
    sclk = 1'b0; idle(GAP);
    frame_body(1'b0, 3'd0, '0, 0, tmp);
    check("R10 data abort", tmp, 32'd77);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule